// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

The block turns a pixel clock into three free-running raster strobes (vertical sync, horizontal sync and data enable) together with two position outputs for downstream pixel logic. Every strobe is described independently in raw pixel clocks by four settings: a delay from frame start, an asserted length, a deasserted length and a number of pulses. The vertical strobe always makes exactly one pulse. The sum of its asserted and deasserted lengths sets the frame period.

Software loads the eleven settings one byte at a time through a write port and then raises `en_i`. Generation then repeats every frame with no external trigger. A pending change waits in a shadow copy and is taken over only at a frame boundary, so a running raster never sees a half-written value. Dropping `en_i` abandons the frame and silences all outputs.

Top module: `sync_timing_gen`

## Requirements
- R1: While `en_i` is sampled low at a clock edge, including after reset, `vs_o`, `hs_o`, `de_o`, `px_o` and `ln_o` are all 0 in the following cycle. Writes are still accepted during this time.
- R2: Each write stores `wr_data_i` into the byte at `wr_addr_i`. Every setting occupies consecutive addresses with its most significant byte at the lowest address. The byte addresses are: VS delay 0-2, VS high 3-5, VS low 6-8 (24 bits each); HS delay 9-10, HS high 11-12, HS low 13-14, HS pulse count 15-16 (16 bits each); DE delay 17-19 (24 bits); DE high 20-21, DE low 22-23, DE pulse count 24-25 (16 bits each).
- R3: A frame lasts VS high + VS low clocks, and the position t runs from 0 to that length minus 1. The first cycle after `en_i` is sampled high following a low sample has t = 0. Frames then follow one another with no trigger.
- R4: `vs_o` is 1 exactly when delay <= t < delay + high, using the VS settings.
- R5: `hs_o` is 1 exactly when t = delay + k*(high+low) + j with 0 <= j < high and 0 <= k < count. It stays 0 for the rest of the frame once count pulses have been made.
- R6: `de_o` follows the rule of R5 with the DE settings. Its delay is 24 bits wide, and while it is high `ln_o` is below the DE count.
- R7: A high length of 0 or a count of 0 keeps that strobe at 0 for the whole frame. A low length of 0 makes the pulses back to back.
- R8: Writes made while enabled take effect at the next frame start. A write sampled at the edge that ends the last cycle of a frame takes effect one frame later.
- R9: While `de_o` is 1, `px_o` equals the number of clocks since the current DE pulse began; otherwise it is 0. `ln_o` counts the DE pulses completed in the current frame and is 0 at t = 0.
- R10: Dropping `en_i` in mid-frame abandons that frame. Raising it again starts a new frame at t = 0 with the settings as they stand.
- R11: With 1080p settings (VS 0/11000/2464000; HS 0/44/2156/1125; DE 90392/1920/280/1080), VS is high for the first 11000 clocks, HS is high for 44 clocks every 2200, and DE makes 1920-clock pulses every 2200 clocks starting at clock 90392.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 5 | Byte address of the write |
| wr_data_i | input | 8 | Byte to store |
| vs_o | output | 1 | Vertical sync strobe |
| hs_o | output | 1 | Horizontal sync strobe |
| de_o | output | 1 | Data enable strobe |
| px_o | output | 16 | Pixel index inside the current DE pulse |
| ln_o | output | 16 | Completed DE pulses in the current frame |

## Verification
Two events can meet in one edge: the frame wrap that copies the shadow settings into the active set, and a byte write into the shadow. The bench steps the raster until it sits on the last cycle of a frame, presents a DE-length write exactly there, and expects the next frame to keep the old length and the one after to use the new one. A second meeting point is a DE pulse that ends in the same edge as the next one begins (low length 0). There `px_o` must restart at 0 and `ln_o` must advance while `de_o` stays high. Both cases are judged cycle by cycle against an arithmetic model of the raster position.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int BW = 8;
  localparam int VW = 24;
  localparam int HW = 16;
  localparam int VB = VW / BW;
  localparam int HB = HW / BW;
  localparam int FW = VW + 1;

  // byte map, MSB at lowest address of each field
  localparam int A_VS_DLY = 0;
  localparam int A_VS_HI  = A_VS_DLY + VB;
  localparam int A_VS_LO  = A_VS_HI + VB;
  localparam int A_HS_DLY = A_VS_LO + VB;
  localparam int A_HS_HI  = A_HS_DLY + HB;
  localparam int A_HS_LO  = A_HS_HI + HB;
  localparam int A_HS_NUM = A_HS_LO + HB;
  localparam int A_DE_DLY = A_HS_NUM + HB;
  localparam int A_DE_HI  = A_DE_DLY + VB;
  localparam int A_DE_LO  = A_DE_HI + HB;
  localparam int A_DE_NUM = A_DE_LO + HB;
  localparam int NBYTES   = A_DE_NUM + HB;
  localparam int AW       = $clog2(NBYTES);

  typedef struct packed {
    logic [VW-1:0] vs_dly;
    logic [VW-1:0] vs_hi;
    logic [VW-1:0] vs_lo;
    logic [HW-1:0] hs_dly;
    logic [HW-1:0] hs_hi;
    logic [HW-1:0] hs_lo;
    logic [HW-1:0] hs_num;
    logic [VW-1:0] de_dly;
    logic [HW-1:0] de_hi;
    logic [HW-1:0] de_lo;
    logic [HW-1:0] de_num;
  } stg_cfg_t;

  typedef enum logic [1:0] {PH_OFF, PH_WAIT, PH_HIGH, PH_LOW} stg_phase_e;
endpackage

// File: rtl/stg_cfg_regs.sv
module stg_cfg_regs
  import stg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [BW-1:0] wr_data_i,
  input  logic          upd_i,
  output stg_cfg_t      act_o,
  output stg_cfg_t      use_o
);
  logic [BW-1:0]        sh_q [NBYTES];
  logic [NBYTES*BW-1:0] sh_flat;
  stg_cfg_t             sh_cfg;
  stg_cfg_t             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBYTES; i++) sh_q[i] <= '0;
    end else if (wr_en_i && (wr_addr_i < AW'(NBYTES))) begin
      sh_q[wr_addr_i] <= wr_data_i;
    end
  end

  // big-endian flat view: byte 0 is most significant
  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_flat
    assign sh_flat[(NBYTES-1-gi)*BW +: BW] = sh_q[gi];
  end

  assign sh_cfg.vs_dly = sh_flat[(NBYTES-A_VS_DLY-VB)*BW +: VW];
  assign sh_cfg.vs_hi  = sh_flat[(NBYTES-A_VS_HI-VB)*BW +: VW];
  assign sh_cfg.vs_lo  = sh_flat[(NBYTES-A_VS_LO-VB)*BW +: VW];
  assign sh_cfg.hs_dly = sh_flat[(NBYTES-A_HS_DLY-HB)*BW +: HW];
  assign sh_cfg.hs_hi  = sh_flat[(NBYTES-A_HS_HI-HB)*BW +: HW];
  assign sh_cfg.hs_lo  = sh_flat[(NBYTES-A_HS_LO-HB)*BW +: HW];
  assign sh_cfg.hs_num = sh_flat[(NBYTES-A_HS_NUM-HB)*BW +: HW];
  assign sh_cfg.de_dly = sh_flat[(NBYTES-A_DE_DLY-VB)*BW +: VW];
  assign sh_cfg.de_hi  = sh_flat[(NBYTES-A_DE_HI-HB)*BW +: HW];
  assign sh_cfg.de_lo  = sh_flat[(NBYTES-A_DE_LO-HB)*BW +: HW];
  assign sh_cfg.de_num = sh_flat[(NBYTES-A_DE_NUM-HB)*BW +: HW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    act_q <= '0;
    else if (upd_i) act_q <= sh_cfg;
  end

  assign act_o = act_q;
  assign use_o = upd_i ? sh_cfg : act_q;
endmodule

// File: rtl/stg_strobe.sv
module stg_strobe
  import stg_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [DW-1:0] dly_i,
  input  logic [TW-1:0] hi_i,
  input  logic [TW-1:0] lo_i,
  input  logic [NW-1:0] num_i,
  output logic          strobe_o,
  output logic          strobe_nxt_o,
  output logic          last_o
);
  localparam int CW = (DW > TW) ? DW : TW;

  stg_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] npl_q, npl_d;
  logic [NW:0]   npl_inc;
  logic          cnt_end;
  logic          stb_q;

  assign cnt_end = (cnt_q == CW'(1));
  assign npl_inc = {1'b0, npl_q} + (NW+1)'(1);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    npl_d = npl_q;
    if (!run_i) begin
      ph_d  = PH_OFF;
      cnt_d = '0;
      npl_d = '0;
    end else if (load_i) begin
      npl_d = '0;
      if (hi_i == '0 || num_i == '0) begin
        ph_d  = PH_OFF;
        cnt_d = '0;
      end else if (dly_i == '0) begin
        ph_d  = PH_HIGH;
        cnt_d = CW'(hi_i);
      end else begin
        ph_d  = PH_WAIT;
        cnt_d = CW'(dly_i);
      end
    end else begin
      case (ph_q)
        PH_WAIT, PH_LOW: begin
          if (cnt_end) begin
            ph_d  = PH_HIGH;
            cnt_d = CW'(hi_i);
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        PH_HIGH: begin
          if (cnt_end) begin
            npl_d = npl_inc[NW-1:0];
            if (npl_inc == {1'b0, num_i}) begin
              ph_d  = PH_OFF;
              cnt_d = '0;
            end else if (lo_i == '0) begin
              cnt_d = CW'(hi_i);
            end else begin
              ph_d  = PH_LOW;
              cnt_d = CW'(lo_i);
            end
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_OFF;
      cnt_q <= '0;
      npl_q <= '0;
      stb_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      npl_q <= npl_d;
      stb_q <= strobe_nxt_o;
    end
  end

  assign strobe_nxt_o = (ph_d == PH_HIGH);
  assign strobe_o     = stb_q;
  assign last_o       = (ph_q == PH_HIGH) && cnt_end;
endmodule

// File: rtl/stg_pos.sv
module stg_pos
  import stg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          start_i,
  input  logic          de_i,
  input  logic          de_nxt_i,
  input  logic          last_i,
  output logic [HW-1:0] px_o,
  output logic [HW-1:0] ln_o
);
  logic [HW-1:0] px_q, ln_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q <= '0;
      ln_q <= '0;
    end else if (!run_i || start_i) begin
      px_q <= '0;
      ln_q <= '0;
    end else begin
      // a pulse ending this cycle restarts px even if DE stays high
      px_q <= (de_i && de_nxt_i && !last_i) ? px_q + HW'(1) : '0;
      if (last_i) ln_q <= ln_q + HW'(1);
    end
  end

  assign px_o = px_q;
  assign ln_o = ln_q;
endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
  import stg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [BW-1:0] wr_data_i,
  output logic          vs_o,
  output logic          hs_o,
  output logic          de_o,
  output logic [HW-1:0] px_o,
  output logic [HW-1:0] ln_o
);
  stg_cfg_t      cfg_act, cfg_use;
  logic          run_q;
  logic [FW-1:0] fcnt_q, frm_len;
  logic          frm_start, upd;
  logic          de_nxt, de_last;
  logic          vs_nxt_unused, vs_last_unused, hs_nxt_unused, hs_last_unused;

  assign frm_len   = {1'b0, cfg_act.vs_hi} + {1'b0, cfg_act.vs_lo};
  assign frm_start = en_i && (!run_q || ((fcnt_q + FW'(1)) >= frm_len));
  assign upd       = !en_i || frm_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      fcnt_q <= '0;
    end else begin
      run_q  <= en_i;
      fcnt_q <= (upd) ? '0 : fcnt_q + FW'(1);
    end
  end

  stg_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .upd_i     (upd),
    .act_o     (cfg_act),
    .use_o     (cfg_use)
  );

  stg_strobe #(.DW(VW), .TW(VW), .NW(1)) u_vs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (en_i),
    .load_i       (frm_start),
    .dly_i        (cfg_use.vs_dly),
    .hi_i         (cfg_use.vs_hi),
    .lo_i         (cfg_use.vs_lo),
    .num_i        (1'b1),
    .strobe_o     (vs_o),
    .strobe_nxt_o (vs_nxt_unused),
    .last_o       (vs_last_unused)
  );

  stg_strobe #(.DW(HW), .TW(HW), .NW(HW)) u_hs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (en_i),
    .load_i       (frm_start),
    .dly_i        (cfg_use.hs_dly),
    .hi_i         (cfg_use.hs_hi),
    .lo_i         (cfg_use.hs_lo),
    .num_i        (cfg_use.hs_num),
    .strobe_o     (hs_o),
    .strobe_nxt_o (hs_nxt_unused),
    .last_o       (hs_last_unused)
  );

  stg_strobe #(.DW(VW), .TW(HW), .NW(HW)) u_de (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (en_i),
    .load_i       (frm_start),
    .dly_i        (cfg_use.de_dly),
    .hi_i         (cfg_use.de_hi),
    .lo_i         (cfg_use.de_lo),
    .num_i        (cfg_use.de_num),
    .strobe_o     (de_o),
    .strobe_nxt_o (de_nxt),
    .last_o       (de_last)
  );

  stg_pos u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_i),
    .start_i  (frm_start),
    .de_i     (de_o),
    .de_nxt_i (de_nxt),
    .last_i   (de_last),
    .px_o     (px_o),
    .ln_o     (ln_o)
  );
endmodule

// File: rtl/stg_checker.sv
module stg_checker
  import stg_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          frm_start_i,
  input logic          vs_i,
  input logic          hs_i,
  input logic          de_i,
  input logic [HW-1:0] px_i,
  input logic [HW-1:0] ln_i,
  input logic [HW-1:0] de_num_i
);
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!vs_i && !hs_i && !de_i && px_i == '0 && ln_i == '0));

  assert_ln_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_start_i |=> (ln_i == '0));

  assert_px_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |-> (px_i == '0));

  assert_ln_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !frm_start_i) |=> (ln_i == $past(ln_i) || ln_i == $past(ln_i) + HW'(1)));

  assert_de_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_i |-> (ln_i < de_num_i));
endmodule

bind sync_timing_gen stg_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .frm_start_i (frm_start),
  .vs_i        (vs_o),
  .hs_i        (hs_o),
  .de_i        (de_o),
  .px_i        (px_o),
  .ln_i        (ln_o),
  .de_num_i    (cfg_act.de_num)
);

// File: tb/sim_sync_timing_gen.sv
`timescale 1ns/1ps
module sim_sync_timing_gen;
  localparam int NB = 26;
  // byte addresses from R2
  localparam int B_VSD = 0,  B_VSH = 3,  B_VSL = 6;
  localparam int B_HSD = 9,  B_HSH = 11, B_HSL = 13, B_HSN = 15;
  localparam int B_DED = 17, B_DEH = 20, B_DEL = 22, B_DEN = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  dat = '0;
  logic        vs, hs, de;
  logic [15:0] px, ln;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_sh  [NB];
  logic [7:0] m_act [NB];
  bit         m_run = 1'b0;
  longint     m_t = 0;

  always #2.5 clk = ~clk;

  sync_timing_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_en_i(we),
    .wr_addr_i(addr), .wr_data_i(dat),
    .vs_o(vs), .hs_o(hs), .de_o(de), .px_o(px), .ln_o(ln)
  );

  function automatic longint dec(input logic [7:0] a [NB], input int base, input int nb);
    longint v = 0;
    for (int i = 0; i < nb; i++) v = (v << 8) | longint'(a[base+i]);
    return v;
  endfunction

  function automatic bit on_at(input longint t, d, h, l, n);
    if (h == 0 || n == 0 || t < d) return 1'b0;
    return ((t - d) / (h + l) < n) && ((t - d) % (h + l) < h);
  endfunction

  // one clock: check outputs at position m_t, then advance model and drive inputs
  task automatic step(input bit e, input bit w, input int a, input logic [7:0] d, input string tag);
    longint vd, vh, vl, hd, hh, hl, hn, dd, dh, dl, dn, ln_e, px_e, flen;
    bit vs_e, hs_e, de_e;
    vd = dec(m_act, B_VSD, 3); vh = dec(m_act, B_VSH, 3); vl = dec(m_act, B_VSL, 3);
    hd = dec(m_act, B_HSD, 2); hh = dec(m_act, B_HSH, 2); hl = dec(m_act, B_HSL, 2);
    hn = dec(m_act, B_HSN, 2);
    dd = dec(m_act, B_DED, 3); dh = dec(m_act, B_DEH, 2); dl = dec(m_act, B_DEL, 2);
    dn = dec(m_act, B_DEN, 2);
    vs_e = 0; hs_e = 0; de_e = 0; px_e = 0; ln_e = 0;
    if (m_run) begin
      vs_e = on_at(m_t, vd, vh, vl, 1);
      hs_e = on_at(m_t, hd, hh, hl, hn);
      de_e = on_at(m_t, dd, dh, dl, dn);
      if (de_e) px_e = (m_t - dd) % (dh + dl);
      if (dh != 0 && dn != 0 && m_t >= dd + dh) begin
        ln_e = (m_t - dd - dh) / (dh + dl) + 1;
        if (ln_e > dn) ln_e = dn;
      end
    end
    checks++;
    if (vs !== vs_e || hs !== hs_e || de !== de_e || px !== 16'(px_e) || ln !== 16'(ln_e)) begin
      errors++;
      $display("FAIL %s t=%0d got vs%0b hs%0b de%0b px%0d ln%0d exp vs%0b hs%0b de%0b px%0d ln%0d",
               tag, m_t, vs, hs, de, px, ln, vs_e, hs_e, de_e, px_e, ln_e);
    end
    flen = vh + vl;
    if (!e) begin
      m_run = 0; m_t = 0; m_act = m_sh;
    end else if (!m_run || m_t + 1 >= flen) begin
      m_run = 1; m_t = 0; m_act = m_sh;
    end else begin
      m_t++;
    end
    if (w && a < NB) m_sh[a] = d;
    en = e; we = w; addr = 5'(a); dat = d;
    @(negedge clk);
  endtask

  task automatic wr(input int base, input int nb, input longint v, input bit e, input string tag);
    for (int i = 0; i < nb; i++) step(e, 1'b1, base + i, 8'(v >> (8 * (nb - 1 - i))), tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, 8'h00, tag);
  endtask

  task automatic load_all(input longint vd, vh, vl, hd, hh, hl, hn, dd, dh, dl, dn,
                          input bit e, input string tag);
    wr(B_VSD, 3, vd, e, tag); wr(B_VSH, 3, vh, e, tag); wr(B_VSL, 3, vl, e, tag);
    wr(B_HSD, 2, hd, e, tag); wr(B_HSH, 2, hh, e, tag); wr(B_HSL, 2, hl, e, tag);
    wr(B_HSN, 2, hn, e, tag);
    wr(B_DED, 3, dd, e, tag); wr(B_DEH, 2, dh, e, tag); wr(B_DEL, 2, dl, e, tag);
    wr(B_DEN, 2, dn, e, tag);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, disabled
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 8'h00, "R1");
    // R2: byte loading while disabled, outputs stay quiet (R1)
    load_all(0, 3, 37, 1, 2, 6, 4, 6, 5, 3, 3, 1'b0, "R1/R2");
    // R3 R4 R5 R6 R9: three 40-clock frames
    run(120, "R3/R4/R5/R6/R9");
    // R7 R8: live changes -> VS delay 5, HS count 0, DE back to back
    wr(B_VSD, 3, 5, 1'b1, "R8");
    wr(B_HSN, 2, 0, 1'b1, "R8");
    wr(B_DEL, 2, 0, 1'b1, "R8");
    run(120, "R7/R8/R9");
    // R8 corner: write on the last cycle of a frame
    while (!(m_run && m_t == dec(m_act, B_VSH, 3) + dec(m_act, B_VSL, 3) - 1))
      step(1'b1, 1'b0, 0, 8'h00, "R8");
    step(1'b1, 1'b1, B_DEH + 1, 8'd2, "R8");
    run(90, "R8");
    // R10: drop enable mid-frame, then restart
    run(17, "R10");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 0, 8'h00, "R10/R1");
    run(60, "R10");
    // R11: 1080p raster, first 100000 clocks
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 8'h00, "R1");
    load_all(0, 11000, 2464000, 0, 44, 2156, 1125, 90392, 1920, 280, 1080, 1'b0, "R2");
    run(100000, "R11");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at t=%0d", m_t);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule